// File: doc/BRIEF.md
# Greedy Maximal Address Search Engine

This block configures a decoder after manufacture, working without help from outside. An address is an M-bit mask over the control lines, and bit i set means line i is driven. The engine presents candidate addresses on a measurement port. For each one it receives one on/off bit per contact group. A result of 1 means nothing in that group stays selected. Results are monotone: if a mask gives 1, then every mask that contains it also gives 1. The engine grows each seed, one line at a time, into a mask that cannot be extended any further in every contact group. It stores each such maximal mask, tagged with its group, in an internal table.

Seeds are visited by population count, fewest active lines first, and in ascending numeric order within one count. A group does not expand a seed that is contained in, or contains, a mask already stored for that group. A candidate that contains a stored mask is rejected without a measurement. Groups that would test the same candidate share one measurement. The search stops when the requested number of entries is stored, or after the all-ones seed. The table is read back through a combinational read port.

Top module: `sa_engine`

## Requirements
- R1: After reset, `done`, `meas_req`, `found_count` and `meas_count` are all 0.
- R2: Seeds are taken in order of population count from 0 to M. Within one count they are taken in ascending numeric order. Each seed that at least one group expands is measured exactly once, before any line is added to it.
- R3: A group skips a seed that is a subset or a superset of a mask stored for that group. If every group skips the seed, no measurement is made for it.
- R4: Expansion tries lines 0 to M-1 in ascending order and skips lines already in the group's mask. It keeps a line exactly when that group's result bit for the extended mask is 0. A group whose seed result is 1 takes no further part for that seed.
- R5: A candidate that is a superset of a mask stored for its group is rejected without a measurement.
- R6: On one line, all groups whose extended masks are equal share one measurement. A distinct candidate costs its own measurement, and the group with the lowest index goes first.
- R7: After line M-1, each group still taking part writes one entry {group, mask}, in ascending group order. `found_count` grows by one per write, and a mask already stored for that group is never written again.
- R8: Writing stops once `found_count` reaches the limit, which is `max_count` clipped to DEPTH. The engine then raises `done` and keeps it high, with `meas_req` low, until the next accepted start.
- R9: When the limit is not reached, `done` rises after the all-ones seed has been handled.
- R10: `meas_req` stays high with `meas_addr` stable until a cycle where `meas_ack` is high. `meas_result` is sampled in that cycle, and the acknowledge may arrive any number of cycles after the request.
- R11: `meas_count` rises by one for each cycle with both `meas_req` and `meas_ack` high.
- R12: A start pulse is accepted only when the engine is idle or done. It clears the table and both counters and latches `max_count`. A pulse while a search runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new search (idle or done only) |
| max_count | input | $clog2(DEPTH+1) | Number of entries requested |
| meas_req | output | 1 | Measurement request |
| meas_addr | output | M | Mask under test |
| meas_ack | input | 1 | Measurement result valid |
| meas_result | input | G | One result bit per group, 1 = nothing selected |
| done | output | 1 | Search finished |
| found_count | output | $clog2(DEPTH+1) | Entries stored |
| meas_count | output | 32 | Measurements completed |
| rd_idx | input | $clog2(DEPTH) | Table read index |
| rd_group | output | max(1,$clog2(G)) | Group of the entry read (0 if empty) |
| rd_mask | output | M | Mask of the entry read (0 if empty) |

## Verification
The assertions assume three things of the environment. It answers every request with exactly one `meas_ack` pulse. It leaves `meas_ack` low while no request is pending. It pulses `start` no more than it needs to. The bench responder drives `meas_ack` only while `meas_req` is high, drops it in the following cycle, and varies the reply delay from zero to two cycles. Its answers come from a monotone model in which each group holds a few elements, and each element is deselected by its own set of lines. This keeps every result consistent with the ordering that the skip rules rely on.

// File: rtl/sa_pkg.sv
// Shared declarations for the maximal address search engine.
// Holds the controller state encoding; widths stay with the modules.
package sa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED_CHK,
        ST_SEED_MEAS,
        ST_LINE,
        ST_LINE_MEAS,
        ST_COMMIT,
        ST_NEXT,
        ST_DONE
    } sa_state_e;

endpackage

// File: rtl/sa_seed_gen.sv
// Seed enumerator: walks every M-bit mask in order of population count
// (0 .. M). Within one count it steps to the next larger mask with the
// same count, using the lowest-set-bit ripple trick. Raises exhausted
// once the all-ones mask has been passed. Assumes M >= 2.
module sa_seed_gen #(
    parameter int M = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    output logic [M-1:0] seed,
    output logic         exhausted
);

    logic [M-1:0] seed_q;
    logic         exh_q;
    logic [M-1:0] seed_nxt;
    logic [M:0]   v_w, low_w, ripple_w, ones_w, gos_w;
    logic [M-1:0] fill_w;
    int           tz;
    int           pc;

    // Next mask with the same popcount, or the first mask of the next popcount.
    always_comb begin
        v_w      = {1'b0, seed_q};
        low_w    = v_w & (~v_w + 1'b1);
        ripple_w = v_w + low_w;
        tz = 0;
        for (int b = M - 1; b >= 0; b--) begin
            if (seed_q[b]) tz = b;
        end
        ones_w = (v_w ^ ripple_w) >> (tz + 2);
        gos_w  = ripple_w | ones_w;
        pc = $countones(seed_q);
        for (int b = 0; b < M; b++) begin
            fill_w[b] = (b <= pc);
        end
        if (seed_q == '0)
            seed_nxt = M'(1);
        else if (gos_w[M])
            seed_nxt = fill_w;
        else
            seed_nxt = gos_w[M-1:0];
    end

    // Seed register and end-of-space flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seed_q <= '0;
            exh_q  <= 1'b0;
        end else if (advance && !exh_q) begin
            if (&seed_q)
                exh_q <= 1'b1;
            else
                seed_q <= seed_nxt;
        end
    end

    assign seed      = seed_q;
    assign exhausted = exh_q;

endmodule

// File: rtl/sa_max_table.sv
// Result table of {group, mask} entries, filled in order. A combinational
// query reports, per group, whether the query mask is a subset of, a
// superset of, or equal to any stored mask of that group. Writes go to
// slot fill; the caller keeps fill below DEPTH. DEPTH is a power of two.
module sa_max_table #(
    parameter int M     = 6,
    parameter int G     = 2,
    parameter int DEPTH = 64,
    parameter int GW    = 1,
    parameter int IW    = 6,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [GW-1:0] wr_group,
    input  logic [M-1:0]  wr_mask,
    input  logic [M-1:0]  q_mask,
    output logic [G-1:0]  q_sub,
    output logic [G-1:0]  q_sup,
    output logic [G-1:0]  q_eq,
    input  logic [IW-1:0] rd_idx,
    output logic [GW-1:0] rd_group,
    output logic [M-1:0]  rd_mask,
    output logic [CW-1:0] fill
);

    logic [GW-1:0]    grp_q [DEPTH];
    logic [M-1:0]     msk_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [CW-1:0]    fill_q;
    logic [DEPTH-1:0] e_sub, e_sup, e_eq;

    // Per-entry containment tests against the query mask.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign e_sub[e] = valid_q[e] && ((q_mask & ~msk_q[e]) == '0);
        assign e_sup[e] = valid_q[e] && ((msk_q[e] & ~q_mask) == '0);
        assign e_eq[e]  = valid_q[e] && (msk_q[e] == q_mask);
    end

    // Fold entry hits into per-group flags.
    always_comb begin
        q_sub = '0;
        q_sup = '0;
        q_eq  = '0;
        for (int e = 0; e < DEPTH; e++) begin
            for (int g = 0; g < G; g++) begin
                if (grp_q[e] == GW'(g)) begin
                    if (e_sub[e]) q_sub[g] = 1'b1;
                    if (e_sup[e]) q_sup[g] = 1'b1;
                    if (e_eq[e])  q_eq[g]  = 1'b1;
                end
            end
        end
    end

    // Entry payload storage, written at the fill pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            grp_q[fill_q[IW-1:0]] <= wr_group;
            msk_q[fill_q[IW-1:0]] <= wr_mask;
        end
    end

    // Valid bits and fill pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= '0;
            fill_q  <= '0;
        end else if (wr_en) begin
            valid_q[fill_q[IW-1:0]] <= 1'b1;
            fill_q <= fill_q + 1'b1;
        end
    end

    assign rd_group = valid_q[rd_idx] ? grp_q[rd_idx] : '0;
    assign rd_mask  = valid_q[rd_idx] ? msk_q[rd_idx] : '0;
    assign fill     = fill_q;

endmodule

// File: rtl/sa_engine.sv
// Top of the maximal address search. Sequences seeds, expands each one
// greedily in all groups together (one measurement per distinct
// candidate), prunes with the stored table and records the results.
// Assumes the measurement side answers each request with one ack pulse
// and that its results are monotone. M >= 2, DEPTH a power of two.
module sa_engine
    import sa_pkg::*;
#(
    parameter int M     = 6,
    parameter int G     = 2,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH),
    localparam int GW   = (G > 1) ? $clog2(G) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] max_count,
    output logic          meas_req,
    output logic [M-1:0]  meas_addr,
    input  logic          meas_ack,
    input  logic [G-1:0]  meas_result,
    output logic          done,
    output logic [CW-1:0] found_count,
    output logic [31:0]   meas_count,
    input  logic [IW-1:0] rd_idx,
    output logic [GW-1:0] rd_group,
    output logic [M-1:0]  rd_mask
);

    localparam int LW = $clog2(M);

    sa_state_e     state_q;
    logic [M-1:0]  seed;
    logic          seed_exh;
    logic [CW-1:0] fill;
    logic [CW-1:0] limit_q;
    logic [M-1:0]  cur_q [G];
    logic [G-1:0]  live_q, handled_q, pend_q;
    logic [LW-1:0] line_q;
    logic [GW-1:0] cg_q;
    logic [M-1:0]  cand_q, addr_q;
    logic [31:0]   mcnt_q;

    logic          start_ok;
    logic [M-1:0]  q_mask;
    logic [G-1:0]  q_sub, q_sup, q_eq;
    logic          wr_en;
    logic          seed_adv;
    logic [M-1:0]  bitm, cand;
    logic [G-1:0]  need, match, rej, tst, live_n;
    logic [GW-1:0] lead;

    assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);

    sa_seed_gen #(.M(M)) u_seed (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start_ok),
        .advance   (seed_adv),
        .seed      (seed),
        .exhausted (seed_exh)
    );

    sa_max_table #(
        .M(M), .G(G), .DEPTH(DEPTH), .GW(GW), .IW(IW), .CW(CW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .wr_en    (wr_en),
        .wr_group (cg_q),
        .wr_mask  (cur_q[cg_q]),
        .q_mask   (q_mask),
        .q_sub    (q_sub),
        .q_sup    (q_sup),
        .q_eq     (q_eq),
        .rd_idx   (rd_idx),
        .rd_group (rd_group),
        .rd_mask  (rd_mask),
        .fill     (fill)
    );

    // Line step: groups still needing this line, lead group and its candidate.
    always_comb begin
        bitm = M'(1) << line_q;
        for (int g = 0; g < G; g++) begin
            need[g] = live_q[g] && !cur_q[g][line_q] && !handled_q[g];
        end
        lead = '0;
        for (int g = G - 1; g >= 0; g--) begin
            if (need[g]) lead = GW'(g);
        end
        cand = cur_q[lead] | bitm;
        for (int g = 0; g < G; g++) begin
            match[g] = need[g] && ((cur_q[g] | bitm) == cand);
        end
        rej    = match & q_sup;
        tst    = match & ~q_sup;
        live_n = ~q_sub & ~q_sup;
    end

    // Table query source depends on the phase.
    always_comb begin
        case (state_q)
            ST_LINE:   q_mask = cand;
            ST_COMMIT: q_mask = cur_q[cg_q];
            default:   q_mask = seed;
        endcase
    end

    assign wr_en    = (state_q == ST_COMMIT) && live_q[cg_q] &&
                      (fill < limit_q) && !q_eq[cg_q];
    assign seed_adv = (state_q == ST_NEXT) && (fill < limit_q);

    // Main search sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            limit_q   <= '0;
            live_q    <= '0;
            handled_q <= '0;
            pend_q    <= '0;
            line_q    <= '0;
            cg_q      <= '0;
            cand_q    <= '0;
            addr_q    <= '0;
            for (int g = 0; g < G; g++) cur_q[g] <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        limit_q <= (max_count > CW'(DEPTH)) ? CW'(DEPTH) : max_count;
                        state_q <= ST_SEED_CHK;
                    end
                end
                ST_SEED_CHK: begin
                    if (seed_exh || fill >= limit_q) begin
                        state_q <= ST_DONE;
                    end else if (live_n == '0) begin
                        state_q <= ST_NEXT;
                    end else begin
                        for (int g = 0; g < G; g++) cur_q[g] <= seed;
                        live_q  <= live_n;
                        addr_q  <= seed;
                        state_q <= ST_SEED_MEAS;
                    end
                end
                ST_SEED_MEAS: begin
                    if (meas_ack) begin
                        live_q    <= live_q & ~meas_result;
                        line_q    <= '0;
                        handled_q <= '0;
                        state_q   <= ST_LINE;
                    end
                end
                ST_LINE: begin
                    if (need == '0) begin
                        handled_q <= '0;
                        if (line_q == LW'(M - 1)) begin
                            cg_q    <= '0;
                            state_q <= ST_COMMIT;
                        end else begin
                            line_q <= line_q + 1'b1;
                        end
                    end else begin
                        handled_q <= handled_q | rej;
                        if (tst != '0) begin
                            pend_q  <= tst;
                            cand_q  <= cand;
                            addr_q  <= cand;
                            state_q <= ST_LINE_MEAS;
                        end
                    end
                end
                ST_LINE_MEAS: begin
                    if (meas_ack) begin
                        for (int g = 0; g < G; g++) begin
                            if (pend_q[g] && !meas_result[g]) cur_q[g] <= cand_q;
                        end
                        handled_q <= handled_q | pend_q;
                        state_q   <= ST_LINE;
                    end
                end
                ST_COMMIT: begin
                    if (cg_q == GW'(G - 1))
                        state_q <= ST_NEXT;
                    else
                        cg_q <= cg_q + 1'b1;
                end
                ST_NEXT: begin
                    state_q <= (fill >= limit_q) ? ST_DONE : ST_SEED_CHK;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completed-measurement counter.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok)
            mcnt_q <= '0;
        else if (meas_req && meas_ack)
            mcnt_q <= mcnt_q + 32'd1;
    end

    assign meas_req    = (state_q == ST_SEED_MEAS) || (state_q == ST_LINE_MEAS);
    assign meas_addr   = addr_q;
    assign done        = (state_q == ST_DONE);
    assign found_count = fill;
    assign meas_count  = mcnt_q;

endmodule

// File: rtl/sa_engine_chk.sv
// Port-level protocol and counter checks for sa_engine, attached by bind.
// Assumes meas_ack pulses only while meas_req is high.
module sa_engine_chk #(
    parameter int M     = 6,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          meas_req,
    input logic [M-1:0]  meas_addr,
    input logic          meas_ack,
    input logic          done,
    input logic [CW-1:0] found_count,
    input logic [31:0]   meas_count
);

    logic armed_q;

    // Marks that one clean cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req && !meas_ack |=> meas_req && $stable(meas_addr));

    assert_req_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $fell(meas_req) |-> $past(meas_ack));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !meas_req);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    assert_found_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        found_count <= CW'(DEPTH));

    assert_meas_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(start) |->
            meas_count == $past(meas_count) + 32'($past(meas_req && meas_ack)));

    assert_found_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(start) |->
            (found_count == $past(found_count)) ||
            (found_count == $past(found_count) + 1'b1));

endmodule

bind sa_engine sa_engine_chk #(.M(M), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .meas_req    (meas_req),
    .meas_addr   (meas_addr),
    .meas_ack    (meas_ack),
    .done        (done),
    .found_count (found_count),
    .meas_count  (meas_count)
);

// File: tb/sa_engine_tb.sv
// Bench: monotone oracle responder plus a behavioural model that predicts
// the measurement address stream and the final table contents.
module sa_engine_tb;

    localparam int M = 6;
    localparam int G = 2;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] max_count = '0;
    logic       meas_req;
    logic [5:0] meas_addr;
    logic       meas_ack = 1'b0;
    logic [1:0] meas_result = '0;
    logic       done;
    logic [6:0] found_count;
    logic [31:0] meas_count;
    logic [5:0] rd_idx = '0;
    logic [0:0] rd_group;
    logic [5:0] rd_mask;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [5:0] kill [2][3];
    logic [5:0] e_addr [$];
    logic [0:0] e_grp [$];
    logic [5:0] e_msk [$];
    int         e_meas;
    int         dly = 0;
    int         dly_sel = 0;

    always #4 clk = ~clk;

    sa_engine #(.M(M), .G(G), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .max_count(max_count),
        .meas_req(meas_req), .meas_addr(meas_addr), .meas_ack(meas_ack),
        .meas_result(meas_result), .done(done), .found_count(found_count),
        .meas_count(meas_count), .rd_idx(rd_idx), .rd_group(rd_group),
        .rd_mask(rd_mask)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Group g reads 1 when every element is deselected by some active line.
    function automatic logic [1:0] orc(logic [5:0] w);
        logic [1:0] r;
        for (int g = 0; g < 2; g++) begin
            r[g] = 1'b1;
            for (int n = 0; n < 3; n++) if ((w & kill[g][n]) == '0) r[g] = 1'b0;
        end
        return r;
    endfunction

    task automatic set_pat(int p);
        if (p == 0) begin
            kill[0][0] = 6'b000011; kill[0][1] = 6'b001100; kill[0][2] = 6'b110000;
            kill[1][0] = 6'b000101; kill[1][1] = 6'b011000; kill[1][2] = 6'b100010;
        end else begin
            kill[0][0] = 6'b000001; kill[0][1] = 6'b000110; kill[0][2] = 6'b111000;
            kill[1][0] = 6'b001001; kill[1][1] = 6'b010010; kill[1][2] = 6'b100100;
        end
    endtask

    function automatic bit known(int g, logic [5:0] m, int mode);
        for (int e = 0; e < e_grp.size(); e++) begin
            if (e_grp[e] == 1'(g)) begin
                if (mode == 0 && (((m & ~e_msk[e]) == 0) || ((e_msk[e] & ~m) == 0))) return 1;
                if (mode == 1 && ((e_msk[e] & ~m) == 0)) return 1;
                if (mode == 2 && (e_msk[e] == m)) return 1;
            end
        end
        return 0;
    endfunction

    // Behavioural prediction of the search.
    task automatic build_model(int lim_in);
        int lim;
        bit stop;
        lim = (lim_in > DEPTH) ? DEPTH : lim_in;
        e_addr.delete(); e_grp.delete(); e_msk.delete();
        stop = 0;
        for (int k = 0; k <= M && !stop; k++) begin
            for (int v = 0; v < 64 && !stop; v++) begin
                logic [1:0] live, r;
                logic [5:0] cur [2];
                if ($countones(6'(v)) != k) continue;
                if (e_grp.size() >= lim) begin stop = 1; break; end
                for (int g = 0; g < 2; g++) live[g] = !known(g, 6'(v), 0);
                if (live == 0) continue;
                e_addr.push_back(6'(v));
                r = orc(6'(v));
                live = live & ~r;
                cur[0] = 6'(v); cur[1] = 6'(v);
                for (int i = 0; i < M; i++) begin
                    logic [1:0] hd;
                    hd = 0;
                    forever begin
                        int ld;
                        logic [5:0] cd;
                        logic [1:0] ts;
                        ld = -1;
                        for (int g = 1; g >= 0; g--)
                            if (live[g] && !cur[g][i] && !hd[g]) ld = g;
                        if (ld < 0) break;
                        cd = cur[ld] | (6'd1 << i);
                        ts = 0;
                        for (int g = 0; g < 2; g++) begin
                            if (live[g] && !cur[g][i] && !hd[g] && ((cur[g] | (6'd1 << i)) == cd)) begin
                                if (known(g, cd, 1)) hd[g] = 1;
                                else ts[g] = 1;
                            end
                        end
                        if (ts != 0) begin
                            e_addr.push_back(cd);
                            r = orc(cd);
                            for (int g = 0; g < 2; g++) if (ts[g] && !r[g]) cur[g] = cd;
                            hd = hd | ts;
                        end
                    end
                end
                for (int g = 0; g < 2; g++) begin
                    if (live[g] && e_grp.size() < lim && !known(g, cur[g], 2)) begin
                        e_grp.push_back(1'(g));
                        e_msk.push_back(cur[g]);
                    end
                end
            end
        end
        e_meas = e_addr.size();
    endtask

    // Oracle responder with a varying reply delay; checks each request address.
    always @(negedge clk) begin
        if (meas_ack) begin
            meas_ack <= 1'b0;
        end else if (meas_req) begin
            if (dly > 0) begin
                dly <= dly - 1;
            end else begin
                meas_ack    <= 1'b1;
                meas_result <= orc(meas_addr);
                if (e_addr.size() == 0)
                    chk("R2 R3 unexpected measurement", 32'(meas_addr), 32'hFFFFFFFF);
                else
                    chk("R2 R3 R4 R5 R6 R10 meas_addr", 32'(meas_addr), 32'(e_addr.pop_front()));
                dly_sel = dly_sel + 1;
                dly <= dly_sel % 3;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(int pat, int lim, bit poke);
        int t;
        set_pat(pat);
        build_model(lim);
        @(negedge clk); start = 1'b1; max_count = 7'(lim);
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            chk("R12 still busy before stray start", 32'(done), 32'd0);
            start = 1'b1; max_count = 7'd1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk("R8 R9 done raised", 32'(done), 32'd1);
        chk("R7 R12 found_count", 32'(found_count), 32'(e_grp.size()));
        chk("R11 R12 meas_count", 32'(meas_count), 32'(e_meas));
        chk("R2 all predicted measurements issued", 32'(e_addr.size()), 32'd0);
        for (int i = 0; i < e_grp.size(); i++) begin
            @(negedge clk); rd_idx = 6'(i);
            #1;
            chk("R7 table entry", {25'd0, rd_group, rd_mask}, {25'd0, e_grp[i], e_msk[i]});
        end
        repeat (4) @(negedge clk);
        chk("R8 done held", 32'(done), 32'd1);
        chk("R8 no request after done", 32'(meas_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 meas_req after reset", 32'(meas_req), 32'd0);
        chk("R1 found_count after reset", 32'(found_count), 32'd0);
        chk("R1 meas_count after reset", 32'(meas_count), 32'd0);
        run(0, 64, 0);
        run(0, 1, 0);
        run(0, 3, 0);
        run(1, 64, 1);
        run(1, 0, 0);
        run(1, 100, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule